// File: doc/BRIEF.md
# DDR2 Mode Register Load Sequencer

This block turns one configuration request into one DDR2 mode-register write. A request names the target (the main mode register or one of the three extended mode registers) and carries the fields for it. These fields are burst length and ordering, CAS latency, a write-recovery time in picoseconds, DLL reset, power-down exit speed, DLL disable, reduced output drive, on-die termination, additive latency, off-chip driver calibration control and strobe disable. For the second and third extended registers a raw 13-bit payload is used. The block checks the request and packs it onto the address and bank pins. It drives one command cycle with chip select, RAS, CAS and WE all low, and then keeps the command bus on NOP for the mode-register cycle time before it takes another request.

Requests enter through a valid/ready handshake. Ready is high only when no cycle-time wait is pending, every bank is reported precharged and clock enable is high. A request is transferred on a clock edge where valid and ready are both high. While ready is low the requester holds valid high and keeps every field stable. A transferred request that has an illegal code is dropped with a one-cycle error pulse, and no command is issued for it. A completed wait is marked by a one-cycle done pulse.

Top module: `ddr2_modereg_loader`

## Requirements
- R1: `req_ready` is high exactly when no wait is pending, `banks_idle` is high and `cke` is high. While either precondition is low no command is issued, whatever `req_valid` does.
- R2: A legal request transferred at edge e produces exactly one command cycle, in the cycle after e, with `cmd_cs_n`, `cmd_ras_n`, `cmd_cas_n` and `cmd_we_n` all 0. In every other cycle the bus shows NOP (`cmd_cs_n` 0, the other three 1).
- R3: During a command `cmd_ba[1:0]` equals `req_target` (0 main, 1 extended 1, 2 extended 2, 3 extended 3) and `cmd_ba[2]` is 0.
- R4: Main register layout: A[2:0] = 3'b010 for burst 4 or 3'b011 for burst 8 (`req_burst8`). A3 = `req_interleave`. A[6:4] = CAS latency in cycles. A7 = 0. A8 = `req_dll_reset`. A[11:9] = write-recovery code. A12 = `req_slow_exit`.
- R5: The write-recovery cycle count is ceil(`req_twr_ps` / TCK_PS). A count below 2 is raised to 2. The code written is the count minus 1, so codes 1 to 7 stand for 2 to 8 cycles. A count above 8 makes a main-register request illegal.
- R6: A main-register request is illegal if its CAS latency is outside 3 to 6 or if `req_test_mode` is 1. An extended-1 request is illegal if its additive latency is above 5.
- R7: Extended 1 layout: A0 = `req_dll_disable`, A1 = `req_reduced_drive`, A2 = `req_odt[0]`, A6 = `req_odt[1]`, A[5:3] = `req_add_lat`, A[9:7] = `req_ocd`, A10 = `req_dqs_disable`, A11 = A12 = 0.
- R8: For extended 2 and 3 the address equals `req_ext_data`. Main-register and extended-1 fields have no effect on these targets, and such requests are always legal.
- R9: An illegal transferred request gives `err` high for exactly the next cycle. In that cycle the bus stays NOP and `busy` stays low.
- R10: `busy` is high from the command cycle through the next TMRD-1 cycles, counting the command cycle (with the default TMRD=2 that is the command cycle only). `done` pulses for one cycle right after that, and `req_ready` goes high in that same cycle. Two commands are therefore never closer than TMRD cycles.
- R11: After reset the bus is NOP, `cmd_ba` and `cmd_addr` are 0, and `busy`, `done` and `err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be transferred |
| req_target | input | 2 | Target register select |
| req_burst8 | input | 1 | 1 selects burst 8, 0 selects burst 4 |
| req_interleave | input | 1 | Interleaved burst ordering |
| req_cas_lat | input | 3 | CAS latency in cycles |
| req_twr_ps | input | TWR_W | Write-recovery time in picoseconds |
| req_dll_reset | input | 1 | DLL reset bit |
| req_slow_exit | input | 1 | Slow power-down exit |
| req_test_mode | input | 1 | Test-mode request (always rejected) |
| req_dll_disable | input | 1 | DLL disable |
| req_reduced_drive | input | 1 | Reduced output drive strength |
| req_odt | input | 2 | Termination setting |
| req_add_lat | input | 3 | Additive latency |
| req_ocd | input | 3 | Driver calibration control |
| req_dqs_disable | input | 1 | Strobe disable |
| req_ext_data | input | 13 | Payload for extended registers 2 and 3 |
| banks_idle | input | 1 | All banks precharged |
| cke | input | 1 | Clock enable is high |
| cmd_cs_n | output | 1 | Chip select |
| cmd_ras_n | output | 1 | Row strobe |
| cmd_cas_n | output | 1 | Column strobe |
| cmd_we_n | output | 1 | Write enable |
| cmd_ba | output | 3 | Bank address |
| cmd_addr | output | 13 | Address bus |
| busy | output | 1 | Cycle-time wait in progress |
| done | output | 1 | Wait completed (pulse) |
| err | output | 1 | Request rejected (pulse) |

## Verification
A packing or legality fault appears on `cmd_addr`, `cmd_ba` or `err` in the first cycle after the transfer, so every swept field value is compared on that cycle. A wait counter that is loaded wrong or stuck shows up within TMRD cycles as a `busy` level that is off, a missing or doubled `done`, or `req_ready` rising too early or never. The bench therefore checks all three signals on each cycle of every request. A fault in the precondition gating shows as `req_ready` high, or a command on the bus, while `banks_idle` or `cke` is low.

// File: rtl/mrl_pkg.sv
package mrl_pkg;
  localparam int MRL_ADDR_W = 13;
  localparam int MRL_BA_W   = 3;

  typedef enum logic [1:0] {
    TGT_MAIN = 2'd0,
    TGT_EXT1 = 2'd1,
    TGT_EXT2 = 2'd2,
    TGT_EXT3 = 2'd3
  } mrl_target_e;

  function automatic logic cas_lat_legal(input logic [2:0] cl);
    return (cl >= 3'd3) && (cl <= 3'd6);
  endfunction

  function automatic logic add_lat_legal(input logic [2:0] al);
    return al <= 3'd5;
  endfunction
endpackage

// File: rtl/mrl_wr_calc.sv
module mrl_wr_calc #(
  parameter int TCK_PS = 2500,
  parameter int TWR_W  = 16
) (
  input  logic [TWR_W-1:0] twr_ps,
  output logic [2:0]       wr_code,
  output logic             wr_ok
);
  localparam int SUM_W = TWR_W + 1;
  localparam logic [SUM_W-1:0] ROUND_UP = SUM_W'(TCK_PS - 1);
  localparam logic [SUM_W-1:0] DIVISOR  = SUM_W'(TCK_PS);

  logic [SUM_W-1:0] padded;
  logic [SUM_W-1:0] cycles;
  logic [SUM_W-1:0] cycles_eff;

  always_comb begin
    padded     = {1'b0, twr_ps} + ROUND_UP;
    cycles     = padded / DIVISOR;
    cycles_eff = (cycles < SUM_W'(2)) ? SUM_W'(2) : cycles;
    wr_ok      = cycles_eff <= SUM_W'(8);
    wr_code    = wr_ok ? 3'(cycles_eff - SUM_W'(1)) : 3'd0;
  end
endmodule

// File: rtl/mrl_field_pack.sv
module mrl_field_pack
  import mrl_pkg::*;
#(
  parameter int TCK_PS = 2500,
  parameter int TWR_W  = 16
) (
  input  logic [1:0]            target,
  input  logic                  burst8,
  input  logic                  interleave,
  input  logic [2:0]            cas_lat,
  input  logic [TWR_W-1:0]      twr_ps,
  input  logic                  dll_reset,
  input  logic                  slow_exit,
  input  logic                  test_mode,
  input  logic                  dll_disable,
  input  logic                  reduced_drive,
  input  logic [1:0]            odt,
  input  logic [2:0]            add_lat,
  input  logic [2:0]            ocd,
  input  logic                  dqs_disable,
  input  logic [MRL_ADDR_W-1:0] ext_data,
  output logic [MRL_BA_W-1:0]   ba,
  output logic [MRL_ADDR_W-1:0] addr,
  output logic                  legal
);
  logic [2:0] wr_code;
  logic       wr_ok;
  mrl_target_e tgt;

  mrl_wr_calc #(.TCK_PS(TCK_PS), .TWR_W(TWR_W)) u_wr (
    .twr_ps (twr_ps),
    .wr_code(wr_code),
    .wr_ok  (wr_ok)
  );

  assign tgt = mrl_target_e'(target);
  assign ba  = {1'b0, target};

  always_comb begin
    addr  = '0;
    legal = 1'b1;
    unique case (tgt)
      TGT_MAIN: begin
        addr  = {slow_exit, wr_code, dll_reset, 1'b0, cas_lat, interleave,
                 1'b0, 1'b1, burst8};
        legal = cas_lat_legal(cas_lat) && !test_mode && wr_ok;
      end
      TGT_EXT1: begin
        addr  = {2'b00, dqs_disable, ocd, odt[1], add_lat, odt[0],
                 reduced_drive, dll_disable};
        legal = add_lat_legal(add_lat);
      end
      default: begin
        addr  = ext_data;
        legal = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/mrl_cmd_issue.sv
module mrl_cmd_issue
  import mrl_pkg::*;
#(
  parameter int TMRD = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fire,
  input  logic                  reject,
  input  logic [MRL_BA_W-1:0]   ba_in,
  input  logic [MRL_ADDR_W-1:0] addr_in,
  output logic                  cs_n,
  output logic                  ras_n,
  output logic                  cas_n,
  output logic                  we_n,
  output logic [MRL_BA_W-1:0]   ba,
  output logic [MRL_ADDR_W-1:0] addr,
  output logic                  busy,
  output logic                  done,
  output logic                  err
);
  localparam int CNT_W = $clog2(TMRD + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(TMRD - 1);

  logic             cmd_on;
  logic [CNT_W-1:0] wait_cnt;
  logic [CNT_W-1:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_on   <= 1'b0;
      ba       <= '0;
      addr     <= '0;
      wait_cnt <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      cmd_on <= fire;
      err    <= reject;
      done   <= (wait_cnt == CNT_W'(1));
      if (fire) begin
        ba       <= ba_in;
        addr     <= addr_in;
        wait_cnt <= LOAD;
      end else if (wait_cnt != '0) begin
        wait_cnt <= wait_cnt - CNT_W'(1);
      end
    end
  end

  assign busy  = wait_cnt != '0;
  assign cs_n  = 1'b0;
  assign ras_n = !cmd_on;
  assign cas_n = !cmd_on;
  assign we_n  = !cmd_on;

  // cycles since the previous command, saturating at TMRD
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 gap <= CNT_W'(TMRD);
    else if (cmd_on)            gap <= CNT_W'(1);
    else if (gap < CNT_W'(TMRD)) gap <= gap + CNT_W'(1);
  end

  a_r10_cmd_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_on |-> (gap >= CNT_W'(TMRD)));
  a_r2_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_on |=> !cmd_on);
  a_r10_busy_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_on |-> busy);
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_err_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!cmd_on && !busy));
endmodule

// File: rtl/ddr2_modereg_loader.sv
module ddr2_modereg_loader
  import mrl_pkg::*;
#(
  parameter int TCK_PS = 2500,
  parameter int TMRD   = 2,
  parameter int TWR_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [1:0]            req_target,
  input  logic                  req_burst8,
  input  logic                  req_interleave,
  input  logic [2:0]            req_cas_lat,
  input  logic [TWR_W-1:0]      req_twr_ps,
  input  logic                  req_dll_reset,
  input  logic                  req_slow_exit,
  input  logic                  req_test_mode,
  input  logic                  req_dll_disable,
  input  logic                  req_reduced_drive,
  input  logic [1:0]            req_odt,
  input  logic [2:0]            req_add_lat,
  input  logic [2:0]            req_ocd,
  input  logic                  req_dqs_disable,
  input  logic [12:0]           req_ext_data,
  input  logic                  banks_idle,
  input  logic                  cke,
  output logic                  cmd_cs_n,
  output logic                  cmd_ras_n,
  output logic                  cmd_cas_n,
  output logic                  cmd_we_n,
  output logic [2:0]            cmd_ba,
  output logic [12:0]           cmd_addr,
  output logic                  busy,
  output logic                  done,
  output logic                  err
);
  logic [MRL_BA_W-1:0]   pk_ba;
  logic [MRL_ADDR_W-1:0] pk_addr;
  logic                  pk_legal;
  logic                  accept;

  mrl_field_pack #(.TCK_PS(TCK_PS), .TWR_W(TWR_W)) u_pack (
    .target       (req_target),
    .burst8       (req_burst8),
    .interleave   (req_interleave),
    .cas_lat      (req_cas_lat),
    .twr_ps       (req_twr_ps),
    .dll_reset    (req_dll_reset),
    .slow_exit    (req_slow_exit),
    .test_mode    (req_test_mode),
    .dll_disable  (req_dll_disable),
    .reduced_drive(req_reduced_drive),
    .odt          (req_odt),
    .add_lat      (req_add_lat),
    .ocd          (req_ocd),
    .dqs_disable  (req_dqs_disable),
    .ext_data     (req_ext_data),
    .ba           (pk_ba),
    .addr         (pk_addr),
    .legal        (pk_legal)
  );

  assign req_ready = !busy && banks_idle && cke;
  assign accept    = req_valid && req_ready;

  mrl_cmd_issue #(.TMRD(TMRD)) u_issue (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (accept && pk_legal),
    .reject (accept && !pk_legal),
    .ba_in  (pk_ba),
    .addr_in(pk_addr),
    .cs_n   (cmd_cs_n),
    .ras_n  (cmd_ras_n),
    .cas_n  (cmd_cas_n),
    .we_n   (cmd_we_n),
    .ba     (cmd_ba),
    .addr   (cmd_addr),
    .busy   (busy),
    .done   (done),
    .err    (err)
  );

  a_r2_legal_issues: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && pk_legal) |=> (!cmd_ras_n && !cmd_cas_n && !cmd_we_n));
  a_r9_illegal_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !pk_legal) |=> (cmd_ras_n && err));
  a_r1_no_cmd_without_cke: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> cmd_ras_n);
  a_r4_test_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_ras_n && cmd_ba[1:0] == 2'd0) |-> !cmd_addr[7]);
  a_r3_ba2_low: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ras_n |-> !cmd_ba[2]);
endmodule

// File: tb/ddr2_modereg_loader_tb.sv
module ddr2_modereg_loader_tb;
  localparam int TCK = 2500;
  localparam int TMRD = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_target = '0;
  logic req_burst8 = 0, req_interleave = 0, req_dll_reset = 0, req_slow_exit = 0;
  logic req_test_mode = 0, req_dll_disable = 0, req_reduced_drive = 0, req_dqs_disable = 0;
  logic [2:0] req_cas_lat = 3'd3, req_add_lat = '0, req_ocd = '0;
  logic [15:0] req_twr_ps = 16'd15000;
  logic [1:0] req_odt = '0;
  logic [12:0] req_ext_data = '0;
  logic banks_idle = 1'b1, cke = 1'b1;
  logic cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n, busy, done, err;
  logic [2:0] cmd_ba;
  logic [12:0] cmd_addr;

  int n_run = 0;
  int n_fail = 0;

  ddr2_modereg_loader #(.TCK_PS(TCK), .TMRD(TMRD), .TWR_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_target(req_target), .req_burst8(req_burst8), .req_interleave(req_interleave),
    .req_cas_lat(req_cas_lat), .req_twr_ps(req_twr_ps), .req_dll_reset(req_dll_reset),
    .req_slow_exit(req_slow_exit), .req_test_mode(req_test_mode),
    .req_dll_disable(req_dll_disable), .req_reduced_drive(req_reduced_drive),
    .req_odt(req_odt), .req_add_lat(req_add_lat), .req_ocd(req_ocd),
    .req_dqs_disable(req_dqs_disable), .req_ext_data(req_ext_data),
    .banks_idle(banks_idle), .cke(cke), .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n),
    .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n), .cmd_ba(cmd_ba), .cmd_addr(cmd_addr),
    .busy(busy), .done(done), .err(err)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int wr_cycles();
    int c = (int'(req_twr_ps) + TCK - 1) / TCK;
    if (c < 2) c = 2;
    return c;
  endfunction

  function automatic bit exp_legal();
    case (req_target)
      2'd0: return (req_cas_lat >= 3 && req_cas_lat <= 6) && !req_test_mode
                   && wr_cycles() <= 8;
      2'd1: return req_add_lat <= 5;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [12:0] exp_addr();
    logic [12:0] a = '0;
    case (req_target)
      2'd0: begin
        a[2:0]  = req_burst8 ? 3'b011 : 3'b010;
        a[3]    = req_interleave;
        a[6:4]  = req_cas_lat;
        a[8]    = req_dll_reset;
        a[11:9] = 3'(wr_cycles() - 1);
        a[12]   = req_slow_exit;
      end
      2'd1: begin
        a[0] = req_dll_disable; a[1] = req_reduced_drive; a[2] = req_odt[0];
        a[5:3] = req_add_lat; a[6] = req_odt[1]; a[9:7] = req_ocd;
        a[10] = req_dqs_disable;
      end
      default: a = req_ext_data;
    endcase
    return a;
  endfunction

  task automatic run_req(input string tag);
    bit lg = exp_legal();
    logic [12:0] ea = exp_addr();
    int guard = 0;
    @(negedge clk);
    req_valid = 1'b1;
    while (!req_ready && guard < 20) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    req_valid = 1'b0;
    if (lg) begin
      chk(!cmd_cs_n && !cmd_ras_n && !cmd_cas_n && !cmd_we_n, "R2 command cycle",
          {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n}, 4'b0000);
      chk(cmd_ba == {1'b0, req_target}, "R3 bank", cmd_ba, {1'b0, req_target});
      chk(cmd_addr == ea, tag, cmd_addr, ea);
      chk(busy && !err && !req_ready, "R10 busy in command cycle",
          {busy, err, req_ready}, 3'b100);
      @(negedge clk);
      chk(cmd_ras_n && cmd_cas_n && cmd_we_n && !cmd_cs_n, "R2 back to NOP",
          {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n}, 4'b0111);
      chk(done && !busy && req_ready, "R10 done and ready", {done, busy, req_ready}, 3'b101);
    end else begin
      chk(err && cmd_ras_n && cmd_cas_n && cmd_we_n && !busy, {tag, " R9 reject"},
          {err, cmd_ras_n, busy}, 3'b110);
      @(negedge clk);
      chk(!err && !done && cmd_ras_n, "R9 err one cycle", {err, done, cmd_ras_n}, 3'b001);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_run, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(cmd_ras_n && cmd_cas_n && cmd_we_n && !cmd_cs_n, "R11 NOP after reset",
        {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n}, 4'b0111);
    chk(cmd_addr == 0 && cmd_ba == 0, "R11 address zero", {cmd_ba, cmd_addr}, 0);
    chk(!busy && !done && !err, "R11 flags low", {busy, done, err}, 0);
    chk(req_ready, "R1 ready when idle", req_ready, 1);

    // R1 hold-off on preconditions
    banks_idle = 1'b0;
    req_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!req_ready && cmd_ras_n, "R1 banks busy holds off", {req_ready, cmd_ras_n}, 2'b01);
    end
    banks_idle = 1'b1;
    cke = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!req_ready && cmd_ras_n, "R1 cke low holds off", {req_ready, cmd_ras_n}, 2'b01);
    end
    req_valid = 1'b0;
    cke = 1'b1;
    @(negedge clk);

    // R4 / R6 main register sweep
    req_target = 2'd0;
    req_twr_ps = 16'd15000;
    for (int b8 = 0; b8 < 2; b8++)
      for (int bt = 0; bt < 2; bt++)
        for (int cl = 0; cl < 8; cl++)
          for (int dr = 0; dr < 2; dr++)
            for (int se = 0; se < 2; se++) begin
              req_burst8 = b8[0]; req_interleave = bt[0]; req_cas_lat = 3'(cl);
              req_dll_reset = dr[0]; req_slow_exit = se[0];
              run_req("R4 main layout / R6 CAS legality");
            end

    // R5 write recovery from picoseconds
    req_cas_lat = 3'd4;
    for (int ps = 0; ps <= 24000; ps += 700) begin
      req_twr_ps = 16'(ps);
      run_req("R5 write recovery code");
    end
    req_twr_ps = 16'd20001;
    run_req("R5 nine cycles rejected");
    req_twr_ps = 16'd20000;
    run_req("R5 exactly eight cycles");

    // R6 test mode rejected
    req_twr_ps = 16'd15000;
    req_test_mode = 1'b1;
    run_req("R6 test mode");
    req_test_mode = 1'b0;

    // R7 / R6 extended 1 sweep
    req_target = 2'd1;
    for (int dd = 0; dd < 2; dd++)
      for (int rd = 0; rd < 2; rd++)
        for (int od = 0; od < 4; od++)
          for (int al = 0; al < 8; al++)
            for (int oc = 0; oc < 8; oc += 3)
              for (int dq = 0; dq < 2; dq++) begin
                req_dll_disable = dd[0]; req_reduced_drive = rd[0]; req_odt = 2'(od);
                req_add_lat = 3'(al); req_ocd = 3'(oc); req_dqs_disable = dq[0];
                run_req("R7 extended 1 layout / R6 additive latency");
              end

    // R8 extended 2 and 3 carry raw payload, other fields ignored
    req_test_mode = 1'b1;
    req_cas_lat = 3'd0;
    req_add_lat = 3'd7;
    for (int t = 2; t < 4; t++)
      for (int k = 0; k < 6; k++) begin
        req_target = 2'(t);
        req_ext_data = 13'((k * 13'h0a5b) ^ (k << 9) ^ 13'h1fff * (k & 1));
        run_req("R8 raw payload");
      end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule